// File: doc/BRIEF.md
# Time-Division RAM Access Scheduler

This block lets three clients share one single-port synchronous RAM without any arbitration. A 2-bit slot counter runs a fixed four-cycle frame, and each cycle belongs to exactly one client. The host bus side owns every other cycle, the network protocol side owns one cycle per frame, and a spare cycle goes either to the network side or to a diagnostic port. A single configuration input picks the owner of the spare cycle. Because the schedule is fixed, each client's bandwidth share is guaranteed and known in advance.

A client raises its request with an address, a write flag and write data, and holds them until it sees a one-cycle accept pulse in one of its own slots. In that cycle the scheduler steers the client's address, data and write enable onto the RAM. A read returns its word one cycle later, together with a one-cycle valid pulse on that client's port only. A slot whose owner has no request leaves the RAM idle. The slot is never handed to anyone else.

The network port may be narrower than the RAM word. Its writes are zero-extended to the full word, and its reads see only the low bits of the word. The RAM is held inside the block as a plain array with no reset.

Top module: `tdmRamSched`

## Requirements
- R1: While `rstN` is low, every accept and every read-valid output is 0, even with all requests raised. The first cycle after reset is released is slot 0.
- R2: The slot number advances by one each cycle and wraps from 3 back to 0. The host is accepted only in slots 0 and 2, in each of those slots where `hostReq` is 1.
- R3: The network port is accepted in slot 1 whenever `netReq` is 1. It is also accepted in slot 3 when `netReq` is 1 and `spareToNet` is 1.
- R4: The diagnostic port is accepted only in slot 3, and only when `spareToNet` is 0 and `diagReq` is 1.
- R5: A request raised outside its owner's slots is ignored: it gets no accept, changes no RAM word and returns no data. A slot whose owner has no request gives no accept to any port. At most one accept is high in any cycle.
- R6: An accepted request with its write flag at 1 stores its write data at its address. The stored word can be read back later through any port.
- R7: An accepted request with its write flag at 0 gives a one-cycle read-valid pulse on the same port in the next cycle. That port's read data holds the word stored at the address, and no other port's read-valid rises.
- R8: No port is accepted in two consecutive cycles.
- R9: An accepted write produces no read-valid pulse in the next cycle.
- R10: A network write stores its `NET_W`-bit value in the low bits of the word and zeros in the upper bits. A network read returns the low `NET_W` bits of the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the RAM and all clients |
| rstN | input | 1 | Active-low asynchronous reset |
| spareToNet | input | 1 | 1: spare slot 3 goes to the network port; 0: it goes to the diagnostic port |
| hostReq | input | 1 | Host request, held until accepted |
| hostWe | input | 1 | Host write flag (1 write, 0 read) |
| hostAddr | input | ADDR_W | Host word address |
| hostWdata | input | DATA_W | Host write data |
| hostAccept | output | 1 | Host request taken this cycle |
| hostRvalid | output | 1 | Host read data valid |
| hostRdata | output | DATA_W | Host read data |
| netReq | input | 1 | Network request, held until accepted |
| netWe | input | 1 | Network write flag |
| netAddr | input | ADDR_W | Network word address |
| netWdata | input | NET_W | Network write data |
| netAccept | output | 1 | Network request taken this cycle |
| netRvalid | output | 1 | Network read data valid |
| netRdata | output | NET_W | Network read data (low bits of the word) |
| diagReq | input | 1 | Diagnostic request, held until accepted |
| diagWe | input | 1 | Diagnostic write flag |
| diagAddr | input | ADDR_W | Diagnostic word address |
| diagWdata | input | DATA_W | Diagnostic write data |
| diagAccept | output | 1 | Diagnostic request taken this cycle |
| diagRvalid | output | 1 | Diagnostic read data valid |
| diagRdata | output | DATA_W | Diagnostic read data |

## Verification
The properties assume that `rstN` changes away from the rising edge and that every request, write flag and the spare-slot selection are at known levels at each edge. Accept is decided from the levels present in the current cycle. The bench drives every input to a defined value at each falling edge. It also keeps reset asserted long enough that the slot counter starts from 0. Outside that, the bench does not honour the hold-until-accepted rule. It varies requests freely from cycle to cycle, so that requests raised in foreign slots are exercised. No property depends on requests being held.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int SLOT_W = 2;
  localparam int FRAME = 1 << SLOT_W;

  typedef enum logic [1:0] {
    OWN_HOST = 2'd0,
    OWN_NET  = 2'd1,
    OWN_DIAG = 2'd2
  } owner_e;

  typedef struct packed {
    owner_e owner;
    logic   access;
    logic   write;
  } strobe_t;

  function automatic owner_e slotOwner(input logic [SLOT_W-1:0] slot, input logic spare);
    owner_e o;
    if (slot[0] == 1'b0) o = OWN_HOST;
    else if (slot == SLOT_W'(1)) o = OWN_NET;
    else if (spare) o = OWN_NET;
    else o = OWN_DIAG;
    return o;
  endfunction
endpackage

// File: rtl/slotCtrl.sv
module slotCtrl
  import tdm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              spareToNet,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic              netReq,
  input  logic              netWe,
  input  logic              diagReq,
  input  logic              diagWe,
  output logic [SLOT_W-1:0] slotNow,
  output logic              hostAccept,
  output logic              netAccept,
  output logic              diagAccept,
  output strobe_t           strobe
);
  logic [SLOT_W-1:0] slotQ;
  owner_e            owner;
  logic              ownerReq;
  logic              ownerWe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slotQ <= '0;
    else       slotQ <= slotQ + SLOT_W'(1);
  end

  always_comb begin
    owner = slotOwner(slotQ, spareToNet);
    unique case (owner)
      OWN_HOST: begin ownerReq = hostReq; ownerWe = hostWe; end
      OWN_NET:  begin ownerReq = netReq;  ownerWe = netWe;  end
      OWN_DIAG: begin ownerReq = diagReq; ownerWe = diagWe; end
      default:  begin ownerReq = 1'b0;    ownerWe = 1'b0;   end
    endcase
  end

  always_comb begin
    strobe.owner  = owner;
    strobe.access = ownerReq & rstN;
    strobe.write  = ownerReq & ownerWe & rstN;
  end

  assign hostAccept = strobe.access && (owner == OWN_HOST);
  assign netAccept  = strobe.access && (owner == OWN_NET);
  assign diagAccept = strobe.access && (owner == OWN_DIAG);
  assign slotNow    = slotQ;
endmodule

// File: rtl/ramPath.sv
module ramPath
  import tdm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 64,
  parameter int NET_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [ADDR_W-1:0] netAddr,
  input  logic [NET_W-1:0]  netWdata,
  input  logic [ADDR_W-1:0] diagAddr,
  input  logic [DATA_W-1:0] diagWdata,
  output logic              hostRvalid,
  output logic [DATA_W-1:0] hostRdata,
  output logic              netRvalid,
  output logic [NET_W-1:0]  netRdata,
  output logic              diagRvalid,
  output logic [DATA_W-1:0] diagRdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] netWide;
  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] selData;
  logic [DATA_W-1:0] rdWordQ;
  logic [2:0]        rvalidQ;
  logic              readNow;

  generate
    if (NET_W < DATA_W) begin : g_netPad
      assign netWide = {{(DATA_W-NET_W){1'b0}}, netWdata};
    end else begin : g_netFull
      assign netWide = netWdata;
    end
  endgenerate

  always_comb begin
    unique case (strobe.owner)
      OWN_HOST: begin selAddr = hostAddr; selData = hostWdata; end
      OWN_NET:  begin selAddr = netAddr;  selData = netWide;   end
      OWN_DIAG: begin selAddr = diagAddr; selData = diagWdata; end
      default:  begin selAddr = '0;       selData = '0;        end
    endcase
  end

  assign readNow = strobe.access & ~strobe.write;

  always_ff @(posedge clk) begin
    if (strobe.write) mem[selAddr] <= selData;
    if (readNow)      rdWordQ <= mem[selAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rvalidQ <= '0;
    end else begin
      rvalidQ[0] <= readNow && (strobe.owner == OWN_HOST);
      rvalidQ[1] <= readNow && (strobe.owner == OWN_NET);
      rvalidQ[2] <= readNow && (strobe.owner == OWN_DIAG);
    end
  end

  assign hostRvalid = rvalidQ[0];
  assign netRvalid  = rvalidQ[1];
  assign diagRvalid = rvalidQ[2];
  assign hostRdata  = rdWordQ;
  assign netRdata   = rdWordQ[NET_W-1:0];
  assign diagRdata  = rdWordQ;
endmodule

// File: rtl/tdmRamSched.sv
module tdmRamSched
  import tdm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 64,
  parameter int NET_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spareToNet,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostAccept,
  output logic              hostRvalid,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              netReq,
  input  logic              netWe,
  input  logic [ADDR_W-1:0] netAddr,
  input  logic [NET_W-1:0]  netWdata,
  output logic              netAccept,
  output logic              netRvalid,
  output logic [NET_W-1:0]  netRdata,
  input  logic              diagReq,
  input  logic              diagWe,
  input  logic [ADDR_W-1:0] diagAddr,
  input  logic [DATA_W-1:0] diagWdata,
  output logic              diagAccept,
  output logic              diagRvalid,
  output logic [DATA_W-1:0] diagRdata
);
  strobe_t           strobe;
  logic [SLOT_W-1:0] slotNow;

  slotCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .spareToNet(spareToNet),
    .hostReq(hostReq), .hostWe(hostWe),
    .netReq(netReq), .netWe(netWe),
    .diagReq(diagReq), .diagWe(diagWe),
    .slotNow(slotNow),
    .hostAccept(hostAccept), .netAccept(netAccept), .diagAccept(diagAccept),
    .strobe(strobe)
  );

  ramPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NET_W(NET_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hostAddr(hostAddr), .hostWdata(hostWdata),
    .netAddr(netAddr), .netWdata(netWdata),
    .diagAddr(diagAddr), .diagWdata(diagWdata),
    .hostRvalid(hostRvalid), .hostRdata(hostRdata),
    .netRvalid(netRvalid), .netRdata(netRdata),
    .diagRvalid(diagRvalid), .diagRdata(diagRdata)
  );
endmodule

// File: rtl/tdmRamSched_chk.sv
module tdmRamSched_chk (
  input logic       clk,
  input logic       rstN,
  input logic       spareToNet,
  input logic [1:0] slotNow,
  input logic       hostReq,
  input logic       hostWe,
  input logic       netReq,
  input logic       netWe,
  input logic       diagReq,
  input logic       diagWe,
  input logic       hostAccept,
  input logic       netAccept,
  input logic       diagAccept,
  input logic       hostRvalid,
  input logic       netRvalid,
  input logic       diagRvalid
);
  always_comb begin
    if (!rstN) begin
      a_r1_quiet_in_reset: assert ({hostAccept, netAccept, diagAccept,
                                    hostRvalid, netRvalid, diagRvalid} == 6'b0);
    end
  end

  a_r2_slot_advance: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> slotNow == $past(slotNow) + 2'd1);

  a_r2_host_even: assert property (@(posedge clk) disable iff (!rstN)
    hostAccept |-> (slotNow[0] == 1'b0 && hostReq));

  a_r3_net_slots: assert property (@(posedge clk) disable iff (!rstN)
    netAccept |-> (netReq && (slotNow == 2'd1 || (slotNow == 2'd3 && spareToNet))));

  a_r4_diag_spare: assert property (@(posedge clk) disable iff (!rstN)
    diagAccept |-> (diagReq && slotNow == 2'd3 && !spareToNet));

  a_r5_one_owner: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hostAccept, netAccept, diagAccept}));

  a_r5_idle_not_lent: assert property (@(posedge clk) disable iff (!rstN)
    (slotNow == 2'd1 && !netReq) |-> !(hostAccept || diagAccept));

  a_r7_host_valid: assert property (@(posedge clk) disable iff (!rstN)
    (hostAccept && !hostWe) |=> hostRvalid);

  a_r7_net_valid: assert property (@(posedge clk) disable iff (!rstN)
    (netAccept && !netWe) |=> netRvalid);

  a_r7_diag_valid: assert property (@(posedge clk) disable iff (!rstN)
    (diagAccept && !diagWe) |=> diagRvalid);

  a_r7_single_valid: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hostRvalid, netRvalid, diagRvalid}));

  a_r8_host_gap: assert property (@(posedge clk) disable iff (!rstN)
    hostAccept |=> !hostAccept);

  a_r8_net_gap: assert property (@(posedge clk) disable iff (!rstN)
    netAccept |=> !netAccept);

  a_r9_write_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    (hostAccept && hostWe) |=> !hostRvalid);
endmodule

bind tdmRamSched tdmRamSched_chk u_chk (
  .clk(clk), .rstN(rstN), .spareToNet(spareToNet), .slotNow(slotNow),
  .hostReq(hostReq), .hostWe(hostWe), .netReq(netReq), .netWe(netWe),
  .diagReq(diagReq), .diagWe(diagWe),
  .hostAccept(hostAccept), .netAccept(netAccept), .diagAccept(diagAccept),
  .hostRvalid(hostRvalid), .netRvalid(netRvalid), .diagRvalid(diagRvalid)
);

// File: tb/tdmRamSched_tb.sv
module tdmRamSched_tb;
  localparam int PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 64;
  localparam int NET_W  = 32;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spareToNet = 1'b0;
  logic hostReq = 1'b0, hostWe = 1'b0, netReq = 1'b0, netWe = 1'b0, diagReq = 1'b0, diagWe = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0, netAddr = '0, diagAddr = '0;
  logic [DATA_W-1:0] hostWdata = '0, diagWdata = '0;
  logic [NET_W-1:0]  netWdata = '0;
  logic hostAccept, netAccept, diagAccept, hostRvalid, netRvalid, diagRvalid;
  logic [DATA_W-1:0] hostRdata, diagRdata;
  logic [NET_W-1:0]  netRdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int expSlot = 0;
  logic [DATA_W-1:0] model [DEPTH];
  logic [2:0]        pendV = '0;
  logic [DATA_W-1:0] pendD [3];

  always #(PERIOD/2) clk = ~clk;

  tdmRamSched #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NET_W(NET_W)) u_dut (
    .clk(clk), .rstN(rstN), .spareToNet(spareToNet),
    .hostReq(hostReq), .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostAccept(hostAccept), .hostRvalid(hostRvalid), .hostRdata(hostRdata),
    .netReq(netReq), .netWe(netWe), .netAddr(netAddr), .netWdata(netWdata),
    .netAccept(netAccept), .netRvalid(netRvalid), .netRdata(netRdata),
    .diagReq(diagReq), .diagWe(diagWe), .diagAddr(diagAddr), .diagWdata(diagWdata),
    .diagAccept(diagAccept), .diagRvalid(diagRvalid), .diagRdata(diagRdata)
  );

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: entered just after a falling edge, returns after the next one.
  task automatic step(input logic [2:0] req, input logic [2:0] we,
                      input logic [ADDR_W-1:0] aH, input logic [ADDR_W-1:0] aN,
                      input logic [ADDR_W-1:0] aD, input logic [DATA_W-1:0] dH,
                      input logic [NET_W-1:0] dN, input logic [DATA_W-1:0] dD);
    int o;
    logic [2:0] expAcc;
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] wd;
    // R7 R9: read-valid and data from the previous cycle's access
    chk("R7/R9 hostRvalid", 64'(hostRvalid), 64'(pendV[0]));
    chk("R7/R9 netRvalid",  64'(netRvalid),  64'(pendV[1]));
    chk("R7/R9 diagRvalid", 64'(diagRvalid), 64'(pendV[2]));
    if (pendV[0]) chk("R6/R7 hostRdata", hostRdata, pendD[0]);
    if (pendV[1]) chk("R10 netRdata", 64'(netRdata), 64'(pendD[1][NET_W-1:0]));
    if (pendV[2]) chk("R6/R7 diagRdata", diagRdata, pendD[2]);
    hostReq = req[0]; netReq = req[1]; diagReq = req[2];
    hostWe = we[0]; netWe = we[1]; diagWe = we[2];
    hostAddr = aH; netAddr = aN; diagAddr = aD;
    hostWdata = dH; netWdata = dN; diagWdata = dD;
    #1;
    o = (expSlot % 2 == 0) ? 0 : (expSlot == 1 ? 1 : (spareToNet ? 1 : 2));
    expAcc = req[o] ? (3'b001 << o) : 3'b000;
    // R2 R3 R4 R5 R8: accepts follow the fixed slot wheel
    chk("R2/R3/R4/R5 accepts", 64'({diagAccept, netAccept, hostAccept}), 64'(expAcc));
    pendV = '0;
    if (expAcc != 3'b000) begin
      a  = (o == 0) ? aH : (o == 1 ? aN : aD);
      wd = (o == 0) ? dH : (o == 1 ? {{(DATA_W-NET_W){1'b0}}, dN} : dD);
      if (we[o]) model[a] = wd;
      else begin
        pendV[o] = 1'b1;
        pendD[o] = model[a];
      end
    end
    @(posedge clk);
    expSlot = (expSlot + 1) % 4;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    hostReq = 1'b1; netReq = 1'b1; diagReq = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1: nothing accepted or returned during reset
    chk("R1 accepts in reset", 64'({diagAccept, netAccept, hostAccept}), 64'(0));
    chk("R1 rvalid in reset", 64'({diagRvalid, netRvalid, hostRvalid}), 64'(0));
    @(negedge clk);
    hostReq = 1'b0; netReq = 1'b0; diagReq = 1'b0;
    rstN = 1'b1;
    expSlot = 0;

    // R6: preload every word through the host (slots 0 and 2)
    for (int n = 0; n < DEPTH; n++) begin
      step(3'b001, 3'b001, ADDR_W'(n), '0, '0, {32'hC0DE0000, 32'(n)}, '0, '0);
      step(3'b000, 3'b000, '0, '0, '0, '0, '0, '0);
    end

    // Sweep: every request/write pattern held over all four slots, both spare settings
    for (int cfg = 0; cfg < 2; cfg++) begin
      spareToNet = cfg[0];
      for (int pat = 0; pat < 64; pat++) begin
        for (int s = 0; s < 4; s++) begin
          int k;
          k = (cfg * 256) + pat * 4 + s;
          step(pat[2:0], pat[5:3], ADDR_W'(k * 5), ADDR_W'(k * 11 + 3), ADDR_W'(k * 13 + 7),
               {32'hA0000000 | 32'(k), 32'h0BAD0000 | 32'(pat)},
               NET_W'(32'h5E000000 | 32'(k)),
               {32'hD1A60000 | 32'(k), 32'(~k)});
        end
      end
    end

    // R10 R6: read every word back through the diagnostic port and the host
    spareToNet = 1'b0;
    for (int n = 0; n < DEPTH; n++) begin
      for (int s = 0; s < 4; s++) step(3'b101, 3'b000, ADDR_W'(n), '0, ADDR_W'(n), '0, '0, '0);
    end
    step(3'b000, 3'b000, '0, '0, '0, '0, '0, '0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule